// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

A first-in first-out buffer that moves 18-bit words from a write clock domain into an independent read clock domain. Writes are taken on rising write-clock edges while the active-low write enable is low, and reads on rising read-clock edges while the active-low read enable is low. Both enables only count while the active-low load input is high; when load is low, the enables are ignored. The depth is a power-of-two parameter from 256 to 4096.

Five active-low status outputs report the fill level: empty, almost-empty, half-full, almost-full and full. The two almost thresholds come from offset inputs that a separate register block supplies; each depth has a conventional default offset: 31 for 256 words, 63 for 512 words and 127 for 1024 words and more. Read data leaves through a registered output. It changes only on an accepted read and is masked to zero while the active-low output enable is high. Pointers cross between the domains as Gray code. A flag driven by the other domain's pointer can therefore trail that domain's activity by up to three destination-clock edges.

Top module: `dual_clock_fifo`

## Requirements
- R1: While rst_ni is low, full_no, almost_full_no and half_full_no are 1, and empty_no and almost_empty_no are 0; after release the buffer holds zero words.
- R2: Reset clears the read data register to all zeros, so rdata_o is 0 with out_en_ni low.
- R3: A write request while full_no is 0 stores nothing, and a read request while empty_no is 0 retrieves nothing and leaves rdata_o unchanged.
- R4: A word reaches rdata_o only on the read-clock edge that accepts a read, including the first word written into an empty buffer; with no accepted read, rdata_o holds its value.
- R5: With no reads pending, full_no goes to 0 on the write-clock edge that stores word number DEPTH, and never while fewer than DEPTH words are held. With no writes pending, empty_no goes to 0 on the read-clock edge that removes the last word.
- R6: almost_full_no is 0 exactly when the word count is at least DEPTH minus full_ofs_i; it is computed on the write clock.
- R7: almost_empty_no is 0 exactly when the word count is at most empty_ofs_i; it is computed on the read clock.
- R8: half_full_no is 0 exactly when the word count exceeds DEPTH/2; it is computed on the write clock.
- R9: While load_ni is 0, neither enable has any effect on the stored words or on rdata_o.
- R10: While out_en_ni is 1, rdata_o is all zeros and rvalid_o is 0; the registered word is kept and appears again once out_en_ni returns to 0.
- R11: With both clocks running and reads and writes interleaved freely, words come out in the order they were written, with no loss and no duplication. Flags driven by the other domain settle within three destination-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wr_en_ni | input | 1 | Write request, active low |
| rd_en_ni | input | 1 | Read request, active low |
| load_ni | input | 1 | Enables qualifier; both requests are ignored while low |
| wdata_i | input | DATA_W | Write data |
| empty_ofs_i | input | OFS_W | Almost-empty threshold n |
| full_ofs_i | input | OFS_W | Almost-full distance m from full |
| out_en_ni | input | 1 | Output enable, active low |
| rdata_o | output | DATA_W | Registered read data, zero while masked |
| rvalid_o | output | 1 | High while the output is enabled |
| empty_no | output | 1 | Empty, active low |
| almost_empty_no | output | 1 | Count at or below n, active low |
| half_full_no | output | 1 | Count above DEPTH/2, active low |
| almost_full_no | output | 1 | Count at or above DEPTH-m, active low |
| full_no | output | 1 | Full, active low |

## Verification
Several properties are checked on every cycle. Pointers must not move on a request refused by full, empty or a low load input, and the read register must hold when no read is requested. Full must imply almost-full and half-full, and empty must imply almost-empty. The exact threshold edges, the first-word latency, data order under two unrelated clocks, and the bounded lag of flags that depend on the other domain are shown only by the bench scenarios. These scenarios are a reset check, a fill to full with refused writes, a drain to empty with refused reads, a load-low window, output masking, and a long interleaved stream with non-default offsets.

// File: rtl/dual_clock_fifo_pkg.sv
`timescale 1ns/1ps
package dual_clock_fifo_pkg;
  // active-high internal flag bundles; ports invert them
  typedef struct packed {
    logic full;
    logic almost_full;
    logic half_full;
  } wr_flags_t;

  typedef struct packed {
    logic empty;
    logic almost_empty;
  } rd_flags_t;
endpackage

// File: rtl/dual_clock_fifo_sync.sv
`timescale 1ns/1ps
module dual_clock_fifo_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dual_clock_fifo_mem.sv
`timescale 1ns/1ps
module dual_clock_fifo_mem #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram_q [DEPTH];
  logic [DW-1:0] out_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) ram_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   out_q <= '0;
    else if (re_i) out_q <= ram_q[raddr_i];
  end

  assign rdata_o = out_q;
endmodule

// File: rtl/dual_clock_fifo_wr_ctrl.sv
`timescale 1ns/1ps
module dual_clock_fifo_wr_ctrl
  import dual_clock_fifo_pkg::*;
#(
  parameter int AW    = 8,
  parameter int OFS_W = 12
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [AW:0]      rgray_sync_i,
  input  logic [OFS_W-1:0] full_ofs_i,
  output logic [AW:0]      wgray_o,
  output logic [AW-1:0]    waddr_o,
  output logic             we_o,
  output wr_flags_t        flags_o
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  logic [AW:0] wbin_q, wbin_nxt, wgray_q, rbin, cnt_nxt;
  wr_flags_t   flags_q;
  int          cnt_i;

  always_comb begin
    rbin[AW] = rgray_sync_i[AW];
    for (int i = AW - 1; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_sync_i[i];
  end

  assign we_o     = push_i && !flags_q.full;
  assign wbin_nxt = wbin_q + {{AW{1'b0}}, we_o};
  assign cnt_nxt  = wbin_nxt - rbin;
  assign cnt_i    = int'(cnt_nxt);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      flags_q <= '0;
    end else begin
      wbin_q              <= wbin_nxt;
      wgray_q             <= wbin_nxt ^ (wbin_nxt >> 1);
      flags_q.full        <= cnt_i == DEPTH;
      flags_q.almost_full <= cnt_i >= DEPTH - int'(full_ofs_i);
      flags_q.half_full   <= cnt_i > HALF;
    end
  end

  assign wgray_o = wgray_q;
  assign waddr_o = wbin_q[AW-1:0];
  assign flags_o = flags_q;

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni) // R3
    (push_i && flags_q.full) |=> $stable(wbin_q));
  AST_FULL_IN_ALMOST_FULL: assert property (@(posedge wclk_i) disable iff (!rst_ni) // R6
    flags_q.full |-> flags_q.almost_full);
  AST_FULL_IN_HALF_FULL: assert property (@(posedge wclk_i) disable iff (!rst_ni) // R8
    flags_q.full |-> flags_q.half_full);
endmodule

// File: rtl/dual_clock_fifo_rd_ctrl.sv
`timescale 1ns/1ps
module dual_clock_fifo_rd_ctrl
  import dual_clock_fifo_pkg::*;
#(
  parameter int AW    = 8,
  parameter int OFS_W = 12
) (
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic [AW:0]      wgray_sync_i,
  input  logic [OFS_W-1:0] empty_ofs_i,
  output logic [AW:0]      rgray_o,
  output logic [AW-1:0]    raddr_o,
  output logic             re_o,
  output rd_flags_t        flags_o
);
  logic [AW:0] rbin_q, rbin_nxt, rgray_q, wbin, cnt_nxt;
  rd_flags_t   flags_q;
  int          cnt_i;

  always_comb begin
    wbin[AW] = wgray_sync_i[AW];
    for (int i = AW - 1; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_sync_i[i];
  end

  assign re_o     = pop_i && !flags_q.empty;
  assign rbin_nxt = rbin_q + {{AW{1'b0}}, re_o};
  assign cnt_nxt  = wbin - rbin_nxt;
  assign cnt_i    = int'(cnt_nxt);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      flags_q <= '1;
    end else begin
      rbin_q               <= rbin_nxt;
      rgray_q              <= rbin_nxt ^ (rbin_nxt >> 1);
      flags_q.empty        <= cnt_i == 0;
      flags_q.almost_empty <= cnt_i <= int'(empty_ofs_i);
    end
  end

  assign rgray_o = rgray_q;
  assign raddr_o = rbin_q[AW-1:0];
  assign flags_o = flags_q;

  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rst_ni) // R3
    (pop_i && flags_q.empty) |=> $stable(rbin_q));
  AST_EMPTY_IN_ALMOST_EMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni) // R7
    flags_q.empty |-> flags_q.almost_empty);
endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo
  import dual_clock_fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  parameter int OFS_W  = 12
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_ni,
  input  logic              rd_en_ni,
  input  logic              load_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFS_W-1:0]  empty_ofs_i,
  input  logic [OFS_W-1:0]  full_ofs_i,
  input  logic              out_en_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              empty_no,
  output logic              almost_empty_no,
  output logic              half_full_no,
  output logic              almost_full_no,
  output logic              full_no
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]       wgray, rgray, wgray_rs, rgray_ws;
  logic [AW-1:0]     waddr, raddr;
  logic              we, re;
  logic [DATA_W-1:0] q;
  wr_flags_t         wflags;
  rd_flags_t         rflags;

  dual_clock_fifo_wr_ctrl #(.AW(AW), .OFS_W(OFS_W)) u_wr (
    .wclk_i, .rst_ni,
    .push_i      (!wr_en_ni && load_ni),
    .rgray_sync_i(rgray_ws),
    .full_ofs_i,
    .wgray_o     (wgray),
    .waddr_o     (waddr),
    .we_o        (we),
    .flags_o     (wflags)
  );

  dual_clock_fifo_rd_ctrl #(.AW(AW), .OFS_W(OFS_W)) u_rd (
    .rclk_i, .rst_ni,
    .pop_i       (!rd_en_ni && load_ni),
    .wgray_sync_i(wgray_rs),
    .empty_ofs_i,
    .rgray_o     (rgray),
    .raddr_o     (raddr),
    .re_o        (re),
    .flags_o     (rflags)
  );

  dual_clock_fifo_sync #(.W(AW + 1)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni, .d_i(wgray), .q_o(wgray_rs)
  );

  dual_clock_fifo_sync #(.W(AW + 1)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni, .d_i(rgray), .q_o(rgray_ws)
  );

  dual_clock_fifo_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .wclk_i, .we_i(we), .waddr_i(waddr), .wdata_i,
    .rclk_i, .rst_ni, .re_i(re), .raddr_i(raddr), .rdata_o(q)
  );

  assign rdata_o         = out_en_ni ? '0 : q;
  assign rvalid_o        = !out_en_ni;
  assign empty_no        = !rflags.empty;
  assign almost_empty_no = !rflags.almost_empty;
  assign half_full_no    = !wflags.half_full;
  assign almost_full_no  = !wflags.almost_full;
  assign full_no         = !wflags.full;

  AST_HOLD_OUTPUT: assert property (@(posedge rclk_i) disable iff (!rst_ni) // R4
    rd_en_ni |=> $stable(q));
  AST_LOAD_GATES_READ: assert property (@(posedge rclk_i) disable iff (!rst_ni) // R9
    !load_ni |=> ($stable(rgray) && $stable(q)));
endmodule

// File: tb/tb_dual_clock_fifo.sv
`timescale 1ns/1ps
module tb_dual_clock_fifo;
  localparam int DW = 18, DEPTH = 256, OW = 12;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en_n = 1, rd_en_n = 1, load_n = 1, oe_n = 0;
  logic [DW-1:0] wdata = '0;
  logic [OW-1:0] eofs = 12'd31, fofs = 12'd31;
  logic [DW-1:0] rdata;
  logic rvalid, empty_n, ae_n, hf_n, af_n, full_n;

  always #5 wclk = ~wclk;   // 100 MHz write clock
  always #7 rclk = ~rclk;   // unrelated read clock

  dual_clock_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .OFS_W(OW)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_ni(wr_en_n), .rd_en_ni(rd_en_n), .load_ni(load_n),
    .wdata_i(wdata), .empty_ofs_i(eofs), .full_ofs_i(fofs), .out_en_ni(oe_n),
    .rdata_o(rdata), .rvalid_o(rvalid), .empty_no(empty_n), .almost_empty_no(ae_n),
    .half_full_no(hf_n), .almost_full_no(af_n), .full_no(full_n)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] model_q[$];
  logic [DW-1:0] exp_d, last_d, next_val = 18'h100;
  bit pend = 0, hold_ok = 0;
  int wr_idle = 0, rd_idle = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // write-side model and checks
  always @(negedge wclk) if (rst_n) begin
    int sz;
    sz = model_q.size();
    if (full_n) chk(sz < DEPTH, "R5 full_no high with model full", sz, DEPTH - 1);
    if (rd_idle >= 8) begin
      chk(full_n == (sz != DEPTH), "R5 full_no level", full_n, sz != DEPTH);
      chk(af_n == (sz < DEPTH - int'(fofs)), "R6 almost_full_no level", af_n, sz < DEPTH - int'(fofs));
      chk(hf_n == (sz <= DEPTH / 2), "R8 half_full_no level", hf_n, sz <= DEPTH / 2);
    end
    if (!wr_en_n && load_n && full_n) model_q.push_back(wdata);
    wr_idle = (!wr_en_n && load_n) ? 0 : wr_idle + 1;
  end

  // read-side model and checks
  always @(negedge rclk) begin
    int sz;
    if (!rst_n) begin
      pend = 0; hold_ok = 0; last_d = '0;
    end else begin
      sz = model_q.size();
      if (pend) chk(rdata == exp_d, "R11 read data order", rdata, exp_d);
      else if (hold_ok && !oe_n) chk(rdata == last_d, "R4 rdata held without read", rdata, last_d);
      pend = 0;
      if (!oe_n) last_d = rdata;
      hold_ok = !oe_n;
      if (wr_idle >= 8) begin
        chk(empty_n == (sz != 0), "R5 empty_no level", empty_n, sz != 0);
        chk(ae_n == (sz > int'(eofs)), "R7 almost_empty_no level", ae_n, sz > int'(eofs));
      end
      if (!rd_en_n && load_n && empty_n) begin
        if (sz == 0) chk(0, "R3 empty_no high with model empty", 0, 1);
        else begin exp_d = model_q.pop_front(); pend = 1; end
      end
      rd_idle = (!rd_en_n && load_n) ? 0 : rd_idle + 1;
    end
  end

  task automatic write_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge wclk); #1; wr_en_n = 0; wdata = next_val; next_val = next_val + 18'd7;
    end
    @(posedge wclk); #1; wr_en_n = 1;
  endtask

  task automatic read_burst(input int n);
    for (int i = 0; i < n; i++) begin @(posedge rclk); #1; rd_en_n = 0; end
    @(posedge rclk); #1; rd_en_n = 1;
  endtask

  task automatic settle();
    repeat (12) @(posedge rclk);
    repeat (12) @(posedge wclk);
    @(negedge wclk); #2;
  endtask

  task automatic do_reset();
    wr_en_n = 1; rd_en_n = 1; load_n = 1; oe_n = 0;
    rst_n = 0;
    model_q.delete();
    repeat (3) @(posedge wclk);
    #2;
    chk(full_n == 1, "R1 full_no in reset", full_n, 1);
    chk(af_n == 1, "R1 almost_full_no in reset", af_n, 1);
    chk(hf_n == 1, "R1 half_full_no in reset", hf_n, 1);
    chk(empty_n == 0, "R1 empty_no in reset", empty_n, 0);
    chk(ae_n == 0, "R1 almost_empty_no in reset", ae_n, 0);
    chk(rdata == '0, "R2 rdata cleared in reset", rdata, 0);
    @(posedge wclk); #1; rst_n = 1;
    wr_idle = 100; rd_idle = 100;
    settle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    do_reset();

    // R4: written words stay invisible until requested
    write_burst(3);
    settle();
    chk(rdata == '0, "R4 first word not shown before read", rdata, 0);
    chk(empty_n == 1, "R5 empty released after writes", empty_n, 1);
    read_burst(3);
    settle();
    chk(empty_n == 0, "R5 empty after draining", empty_n, 0);

    // R3: reads while empty are refused
    held = rdata;
    read_burst(6);
    settle();
    chk(rdata == held, "R3 read on empty leaves rdata", rdata, held);

    // R5/R6/R8: fill to full, then refused writes
    write_burst(DEPTH);
    @(negedge wclk);
    chk(full_n == 0, "R5 full right after DEPTH writes", full_n, 0);
    write_burst(5);
    settle();
    chk(full_n == 0, "R3 still full after refused writes", full_n, 0);
    chk(model_q.size() == DEPTH, "R3 refused writes not stored", model_q.size(), DEPTH);

    // R10: output masking keeps the register
    read_burst(1);
    settle();
    held = rdata;
    oe_n = 1;
    #3;
    chk(rdata == '0, "R10 rdata masked", rdata, 0);
    chk(rvalid == 0, "R10 rvalid low when masked", rvalid, 0);
    repeat (4) @(posedge rclk);
    #3; oe_n = 0; #1;
    chk(rdata == held, "R10 word back after unmask", rdata, held);

    // drain everything: R7 and R5 on the read side
    read_burst(DEPTH + 4);
    settle();
    chk(empty_n == 0 && ae_n == 0, "R7 empty and almost empty after drain", {empty_n, ae_n}, 0);

    // R9: load low blocks both enables
    write_burst(2);
    settle();
    held = rdata;
    load_n = 0;
    fork
      write_burst(20);
      read_burst(20);
    join
    load_n = 1;
    settle();
    chk(rdata == held, "R9 load low leaves rdata", rdata, held);
    chk(model_q.size() == 2, "R9 load low stores nothing", model_q.size(), 2);
    read_burst(2);
    settle();

    // R11: interleaved stream with non-default offsets
    eofs = 12'd5; fofs = 12'd10;
    fork
      for (int i = 0; i < 3000; i++) begin
        @(posedge wclk); #1;
        wr_en_n = ($urandom_range(0, 9) < 6) ? 1'b0 : 1'b1;
        wdata = next_val; next_val = next_val + 18'd13;
      end
      for (int i = 0; i < 2200; i++) begin
        @(posedge rclk); #1;
        rd_en_n = ($urandom_range(0, 9) < 5) ? 1'b0 : 1'b1;
      end
    join
    wr_en_n = 1; rd_en_n = 1;
    settle();
    chk(model_q.size() > 0, "R11 stream leaves data", model_q.size(), 1);
    read_burst(DEPTH + 8);
    settle();
    chk(empty_n == 0, "R11 empty after final drain", empty_n, 0);
    chk(model_q.size() == 0, "R11 model drained", model_q.size(), 0);

    // reset with data present
    write_burst(10);
    settle();
    do_reset();
    chk(empty_n == 0, "R1 buffer empty after reset", empty_n, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule